// File: doc/BRIEF.md
# Address Translation Cache with Page Table Walk

This block turns a virtual page number and byte offset into a physical address. A small fully associative array of recent page-to-frame pairs is searched in one cycle. When the array holds the page, the frame comes back with no memory traffic. When it does not, the block reads a single-level page table in memory, one word per page. That word is fetched from the table base plus the page number, and the result is installed in the array so the next access to that page hits.

Before any lookup the page number is compared with a table length bound. A page beyond the bound faults at once. A table word whose valid bit is clear also faults, and nothing is cached from it. A flush input empties the array in one cycle, for use on an address space switch. Requests are taken only while the block is idle. Every accepted request ends with a single-cycle completion strobe, carrying either a physical address or one fault flag.

Top module: `tlb_unit`

## Requirements
- R1: The physical address is the frame number concatenated above the unchanged offset field; no arithmetic is applied to the offset.
- R2: A request whose page is cached completes with `done` high in the cycle after acceptance, and `mem_rd_req` is never raised for it.
- R3: A request whose page is not cached raises `mem_rd_req` with `mem_rd_addr` equal to `pt_base` plus the zero-extended page number, holds both until `mem_rd_valid`, and completes in the cycle after the response.
- R4: A page number greater than or equal to `pt_len` completes in the cycle after acceptance with `fault_len` high and `paddr` zero, and issues no memory read.
- R5: A table word has its valid bit in the top bit (bit PFN_W) and the frame number in bits PFN_W-1:0. A clear valid bit completes with `fault_inv` high and `paddr` zero, and the page is not cached, so a repeated request misses again.
- R6: A table word with the valid bit set is installed in the array, and the next request for that page hits.
- R7: Fills go to the slot named by a round-robin pointer that starts at slot 0 after reset and advances by one per fill, wrapping after ENTRIES fills, so the oldest fill is the one replaced.
- R8: A one-cycle `flush` pulse invalidates every cached pair; if a fill arrives in the same cycle, the flush wins.
- R9: `idle` is low from acceptance of a missing request until its completion, a `req` seen while not idle is ignored, and `done` is a single-cycle pulse per accepted request.
- R10: After reset `done`, both fault flags and `mem_rd_req` are low, `idle` is high, and the array is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Translation request strobe, taken while idle |
| vpn | input | VPN_W | Virtual page number |
| offset | input | OFF_W | Byte offset within the page |
| pt_base | input | MEM_AW | Word address of the page table |
| pt_len | input | VPN_W+1 | Number of table entries; pages at or above it fault |
| flush | input | 1 | Invalidate all cached pairs |
| mem_rd_req | output | 1 | Table read request, held until answered |
| mem_rd_addr | output | MEM_AW | Table word address |
| mem_rd_valid | input | 1 | Table read data valid |
| mem_rd_data | input | PFN_W+1 | Table word: valid bit on top, frame below |
| done | output | 1 | One-cycle completion strobe |
| paddr | output | PFN_W+OFF_W | Physical address, meaningful when `done` without a fault |
| fault_len | output | 1 | Length fault, with `done` |
| fault_inv | output | 1 | Invalid-entry fault, with `done` |
| idle | output | 1 | Ready for a new request |

## Verification
A corrupted array entry or a stuck match line appears at the ports as a page that should hit but raises a memory read, or as a wrong frame in `paddr`, on the very next request for that page. A round-robin pointer that skips or repeats a slot only becomes visible once the array has wrapped, when the wrong page misses. The bench therefore fills past ENTRIES and probes both the evicted page and a page that should survive. A walker that leaves its state early or late changes the completion latency and the `idle` level, so the bench measures latency per request and injects a request in mid-walk.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int unsigned DEF_VPN_W   = 8;
    localparam int unsigned DEF_OFF_W   = 6;
    localparam int unsigned DEF_PFN_W   = 6;
    localparam int unsigned DEF_ENTRIES = 8;
    localparam int unsigned DEF_MEM_AW  = 16;

    typedef enum logic {
        WALK_IDLE  = 1'b0,
        WALK_FETCH = 1'b1
    } walk_state_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = DEF_ENTRIES,
    parameter int unsigned VPN_W   = DEF_VPN_W,
    parameter int unsigned PFN_W   = DEF_PFN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn
);
    localparam int unsigned PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

    typedef struct packed {
        logic             v;
        logic [VPN_W-1:0] page;
        logic [PFN_W-1:0] frame;
    } slot_t;

    slot_t             slots [ENTRIES];
    logic [PTR_W-1:0]  rr_ptr;
    logic [ENTRIES-1:0] match_vec;
    logic [ENTRIES-1:0] valid_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_match
        assign match_vec[g] = slots[g].v && (slots[g].page == lk_vpn);
        assign valid_vec[g] = slots[g].v;
    end

    always_comb begin
        lk_pfn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            lk_pfn = lk_pfn | ({PFN_W{match_vec[i]}} & slots[i].frame);
        end
    end
    assign lk_hit = |match_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_ptr <= '0;
            for (int i = 0; i < ENTRIES; i++) slots[i] <= '0;
        end else if (flush) begin
            for (int i = 0; i < ENTRIES; i++) slots[i].v <= 1'b0;
        end else if (fill_en) begin
            slots[rr_ptr] <= '{v: 1'b1, page: fill_vpn, frame: fill_pfn};
            rr_ptr        <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
        end
    end

    assert_single_match_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match_vec));
    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_vec == '0));
    assert_rr_step_R7: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !flush) |=>
            (rr_ptr == (($past(rr_ptr) == LAST) ? '0 : $past(rr_ptr) + 1'b1)));
endmodule

// File: rtl/tlb_walker.sv
module tlb_walker
    import tlb_pkg::*;
#(
    parameter int unsigned VPN_W  = DEF_VPN_W,
    parameter int unsigned OFF_W  = DEF_OFF_W,
    parameter int unsigned PFN_W  = DEF_PFN_W,
    parameter int unsigned MEM_AW = DEF_MEM_AW
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req,
    input  logic [VPN_W-1:0]       vpn,
    input  logic [OFF_W-1:0]       offset,
    input  logic [MEM_AW-1:0]      pt_base,
    input  logic [VPN_W:0]         pt_len,
    input  logic                   lk_hit,
    input  logic [PFN_W-1:0]       lk_pfn,
    output logic                   fill_en,
    output logic [VPN_W-1:0]       fill_vpn,
    output logic [PFN_W-1:0]       fill_pfn,
    output logic                   mem_rd_req,
    output logic [MEM_AW-1:0]      mem_rd_addr,
    input  logic                   mem_rd_valid,
    input  logic [PFN_W:0]         mem_rd_data,
    output logic                   done,
    output logic [PFN_W+OFF_W-1:0] paddr,
    output logic                   fault_len,
    output logic                   fault_inv,
    output logic                   idle
);
    walk_state_e         state;
    logic [VPN_W-1:0]    vpn_q;
    logic [OFF_W-1:0]    off_q;
    logic [MEM_AW-1:0]   base_q;
    logic                len_bad;
    logic                pte_ok;

    assign len_bad     = {1'b0, vpn} >= pt_len;
    assign pte_ok      = mem_rd_data[PFN_W];
    assign idle        = (state == WALK_IDLE);
    assign mem_rd_req  = (state == WALK_FETCH);
    assign mem_rd_addr = base_q + {{(MEM_AW-VPN_W){1'b0}}, vpn_q};
    assign fill_en     = (state == WALK_FETCH) && mem_rd_valid && pte_ok;
    assign fill_vpn    = vpn_q;
    assign fill_pfn    = mem_rd_data[PFN_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= WALK_IDLE;
            vpn_q     <= '0;
            off_q     <= '0;
            base_q    <= '0;
            done      <= 1'b0;
            paddr     <= '0;
            fault_len <= 1'b0;
            fault_inv <= 1'b0;
        end else begin
            done      <= 1'b0;
            fault_len <= 1'b0;
            fault_inv <= 1'b0;
            unique case (state)
                WALK_IDLE: if (req) begin
                    vpn_q  <= vpn;
                    off_q  <= offset;
                    base_q <= pt_base;
                    if (len_bad) begin
                        done      <= 1'b1;
                        fault_len <= 1'b1;
                        paddr     <= '0;
                    end else if (lk_hit) begin
                        done  <= 1'b1;
                        paddr <= {lk_pfn, offset};
                    end else begin
                        state <= WALK_FETCH;
                    end
                end
                WALK_FETCH: if (mem_rd_valid) begin
                    done  <= 1'b1;
                    state <= WALK_IDLE;
                    if (pte_ok) begin
                        paddr <= {mem_rd_data[PFN_W-1:0], off_q};
                    end else begin
                        paddr     <= '0;
                        fault_inv <= 1'b1;
                    end
                end
                default: state <= WALK_IDLE;
            endcase
        end
    end

    assert_len_no_read_R4: assert property (@(posedge clk) disable iff (rst)
        (idle && req && len_bad) |=> (!mem_rd_req && done && fault_len));
    assert_read_held_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));
    assert_busy_no_done_R9: assert property (@(posedge clk) disable iff (rst)
        (!idle && !mem_rd_valid) |=> !done);
    assert_fault_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> !(fault_len && fault_inv));
endmodule

// File: rtl/tlb_unit.sv
module tlb_unit
    import tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = DEF_ENTRIES,
    parameter int unsigned VPN_W   = DEF_VPN_W,
    parameter int unsigned OFF_W   = DEF_OFF_W,
    parameter int unsigned PFN_W   = DEF_PFN_W,
    parameter int unsigned MEM_AW  = DEF_MEM_AW
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req,
    input  logic [VPN_W-1:0]       vpn,
    input  logic [OFF_W-1:0]       offset,
    input  logic [MEM_AW-1:0]      pt_base,
    input  logic [VPN_W:0]         pt_len,
    input  logic                   flush,
    output logic                   mem_rd_req,
    output logic [MEM_AW-1:0]      mem_rd_addr,
    input  logic                   mem_rd_valid,
    input  logic [PFN_W:0]         mem_rd_data,
    output logic                   done,
    output logic [PFN_W+OFF_W-1:0] paddr,
    output logic                   fault_len,
    output logic                   fault_inv,
    output logic                   idle
);
    logic             lk_hit;
    logic [PFN_W-1:0] lk_pfn;
    logic             fill_en;
    logic [VPN_W-1:0] fill_vpn;
    logic [PFN_W-1:0] fill_pfn;

    tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_cam (
        .clk(clk), .rst(rst), .flush(flush),
        .lk_vpn(vpn), .lk_hit(lk_hit), .lk_pfn(lk_pfn),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn)
    );

    tlb_walker #(.VPN_W(VPN_W), .OFF_W(OFF_W), .PFN_W(PFN_W), .MEM_AW(MEM_AW)) u_walk (
        .clk(clk), .rst(rst), .req(req), .vpn(vpn), .offset(offset),
        .pt_base(pt_base), .pt_len(pt_len),
        .lk_hit(lk_hit), .lk_pfn(lk_pfn),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .done(done), .paddr(paddr), .fault_len(fault_len),
        .fault_inv(fault_inv), .idle(idle)
    );

    assert_offset_kept_R1: assert property (@(posedge clk) disable iff (rst)
        (idle && req && lk_hit && ({1'b0, vpn} < pt_len)) |=>
            (paddr[OFF_W-1:0] == $past(offset)));
    assert_hit_no_read_R2: assert property (@(posedge clk) disable iff (rst)
        (idle && req && lk_hit) |=> (done && !mem_rd_req));
endmodule

// File: tb/tlb_unit_tb.sv
module tlb_unit_tb;
    localparam int VPN_W = 8, OFF_W = 6, PFN_W = 6, MEM_AW = 16, ENTRIES = 8;
    localparam logic [MEM_AW-1:0] BASE = 16'h0100;
    localparam logic [1:0] K_HIT = 2'd0, K_MISS = 2'd1, K_INV = 2'd2, K_LEN = 2'd3;

    typedef struct packed {
        logic [VPN_W-1:0] page;
        logic [OFF_W-1:0] off;
        logic [1:0]       kind;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{8'd5,   6'd10, K_MISS},
        '{8'd5,   6'd33, K_HIT},
        '{8'd8,   6'd0,  K_INV},
        '{8'd8,   6'd1,  K_INV},
        '{8'd210, 6'd2,  K_LEN},
        '{8'd200, 6'd3,  K_LEN},
        '{8'd199, 6'd63, K_MISS},
        '{8'd199, 6'd0,  K_HIT},
        '{8'd5,   6'd7,  K_HIT}
    };

    logic clk = 1'b0, rst = 1'b1, req = 1'b0, flush = 1'b0;
    logic [VPN_W-1:0] vpn = '0;
    logic [OFF_W-1:0] offset = '0;
    logic [MEM_AW-1:0] pt_base = BASE;
    logic [VPN_W:0] pt_len = 9'd200;
    logic mem_rd_req, mem_rd_valid, done, fault_len, fault_inv, idle;
    logic [MEM_AW-1:0] mem_rd_addr;
    logic [PFN_W:0] mem_rd_data;
    logic [PFN_W+OFF_W-1:0] paddr;
    int n_checks = 0, n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tlb_unit u_dut (
        .clk(clk), .rst(rst), .req(req), .vpn(vpn), .offset(offset),
        .pt_base(pt_base), .pt_len(pt_len), .flush(flush),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .done(done), .paddr(paddr), .fault_len(fault_len),
        .fault_inv(fault_inv), .idle(idle)
    );

    function automatic logic [PFN_W-1:0] frame_of(input int p);
        return PFN_W'((p * 7 + 3) % 64);
    endfunction
    function automatic logic page_ok(input int p);
        return (p % 5) != 3;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_rd_valid <= 1'b0;
            mem_rd_data  <= '0;
        end else if (mem_rd_req && !mem_rd_valid) begin
            mem_rd_valid <= 1'b1;
            mem_rd_data  <= {page_ok(int'(mem_rd_addr - BASE)),
                             frame_of(int'(mem_rd_addr - BASE))};
        end else begin
            mem_rd_valid <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string rq, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic xlate(input logic [VPN_W-1:0] p, input logic [OFF_W-1:0] o,
                         output int lat, output bit rd_seen, output logic [MEM_AW-1:0] rd_addr);
        @(negedge clk);
        req = 1'b1; vpn = p; offset = o;
        @(negedge clk);
        req = 1'b0;
        lat = 1; rd_seen = 1'b0; rd_addr = '0;
        while (!done && lat < 20) begin
            if (mem_rd_req) begin rd_seen = 1'b1; rd_addr = mem_rd_addr; end
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic expect_kind(input logic [VPN_W-1:0] p, input logic [OFF_W-1:0] o,
                               input logic [1:0] k);
        int lat; bit seen; logic [MEM_AW-1:0] ad;
        xlate(p, o, lat, seen, ad);
        check(done == 1'b1, "R9 done", done, 1);
        case (k)
            K_HIT: begin
                check(lat == 1 && !seen, "R2 hit latency", lat, 1);
                check(paddr == {frame_of(p), o}, "R1 hit paddr", paddr, {frame_of(p), o});
                check(!fault_len && !fault_inv, "R2 no fault", {fault_len, fault_inv}, 0);
            end
            K_MISS: begin
                check(lat == 3 && seen, "R3 miss latency", lat, 3);
                check(ad == BASE + p, "R3 table address", ad, BASE + p);
                check(paddr == {frame_of(p), o}, "R1 miss paddr", paddr, {frame_of(p), o});
            end
            K_INV: begin
                check(lat == 3 && seen, "R5 walk then fault", lat, 3);
                check(fault_inv && !fault_len && paddr == '0, "R5 invalid fault",
                      {fault_inv, fault_len}, 2);
            end
            default: begin
                check(lat == 1 && !seen, "R4 no memory read", seen, 0);
                check(fault_len && !fault_inv && paddr == '0, "R4 length fault",
                      {fault_len, fault_inv}, 2);
            end
        endcase
        @(negedge clk);
        check(!done, "R9 single pulse", done, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int lat; bit seen; logic [MEM_AW-1:0] ad; int dones;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(!done && !fault_len && !fault_inv, "R10 outputs", {done, fault_len, fault_inv}, 0);
        check(idle && !mem_rd_req, "R10 idle", {idle, mem_rd_req}, 2);

        foreach (VECS[i]) expect_kind(VECS[i].page, VECS[i].off, VECS[i].kind);

        // R7: slots 0,1 hold 5,199; fill slots 2..7 then wrap onto slot 0
        expect_kind(8'd10, 6'd1, K_MISS);
        expect_kind(8'd11, 6'd1, K_MISS);
        expect_kind(8'd12, 6'd1, K_MISS);
        expect_kind(8'd14, 6'd1, K_MISS);
        expect_kind(8'd15, 6'd1, K_MISS);
        expect_kind(8'd16, 6'd1, K_MISS);
        expect_kind(8'd20, 6'd9, K_MISS);
        expect_kind(8'd199, 6'd4, K_HIT);   // R7 survivor
        expect_kind(8'd5, 6'd4, K_MISS);    // R7 oldest evicted
        expect_kind(8'd10, 6'd5, K_HIT);

        // R8 flush empties the array
        expect_kind(8'd20, 6'd2, K_HIT);
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        expect_kind(8'd20, 6'd2, K_MISS);
        expect_kind(8'd10, 6'd2, K_MISS);

        // R9 request during walk is ignored
        @(negedge clk); req = 1'b1; vpn = 8'd30; offset = 6'd17;
        @(negedge clk); vpn = 8'd1; offset = 6'd3;
        check(!idle, "R9 busy during walk", idle, 0);
        @(negedge clk); req = 1'b0;
        dones = 0;
        for (int c = 0; c < 6; c++) begin
            if (done) begin
                dones++;
                check(paddr == {frame_of(30), 6'd17}, "R9 first request wins",
                      paddr, {frame_of(30), 6'd17});
            end
            @(negedge clk);
        end
        check(dones == 1, "R9 one completion", dones, 1);
        expect_kind(8'd1, 6'd3, K_MISS);   // R9 ignored request was never cached
        expect_kind(8'd30, 6'd0, K_HIT);   // R6 installed fill

        // R4 length bound moved
        pt_len = 9'd1;
        expect_kind(8'd1, 6'd0, K_LEN);
        expect_kind(8'd0, 6'd0, K_MISS);
        pt_len = 9'd256;
        expect_kind(8'd255, 6'd63, K_MISS);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule